// File: doc/BRIEF.md
# Bit-Field Insertion Datapath

This block writes a short bit field into a 32-bit word. The field is the low `len` bits of a source operand `src_fld`. It lands in a destination operand `src_dst`, starting at bit position `off`. Every other bit of the destination passes through unchanged. The datapath builds a contiguous low-order mask of `len` ones by shifting ones into an all-zero word. It uses that mask to trim the field. One left shifter, with one set of select lines, then moves both the mask and the trimmed field up by `off`. A merge stage clears the shifted window in the destination and ORs the shifted field into it.

The block is meant to sit in an execution stage, with `len` and `off` already extracted by the decoder. A parameter chooses the output form: an output register (the default, one cycle of latency, cleared by an active-low asynchronous reset) or a purely combinational output.

Top module: `bfield_insert`

## Requirements
- R1: With `src_dst` = 0 and `src_fld` all ones, the result is a run of exactly `len` ones whose lowest bit sits at position `off`. `len` is a 4-bit unsigned count, 0 to 15.
- R2: Every result bit at position p, where p < `off` or p >= `off`+`len`, equals `src_dst[p]`.
- R3: For each i < `len` with `off`+i <= 31, result bit `off`+i equals `src_fld[i]`.
- R4: Field bits whose target position `off`+i would exceed 31 are dropped. They do not wrap to low bits and do not disturb any other bit. `off` is a 5-bit unsigned position, 0 to 31.
- R5: When `len` = 0, the result equals `src_dst`.
- R6: Bits of `src_fld` at positions `len` and above have no effect on the result.
- R7: In the registered variant, the result for inputs present at a rising clock edge appears just after that edge. While `rst_n` is low, the result is 0.
- R8: With `off` = 0, the field occupies bits 0 to `len`-1 of the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Active-low asynchronous reset of the output register |
| src_dst | input | 32 | Destination word that receives the field |
| src_fld | input | 32 | Word whose low bits form the field |
| len | input | 4 | Field length in bits, 0 to 15 |
| off | input | 5 | Bit position of the field's lowest bit |
| result | output | 32 | Destination word with the field inserted |

## Verification
A fault in the mask generator changes the number of cleared bits. It shows as destination bits that leak through inside the window, or that vanish just above it. A stuck stage in the shared shifter moves the whole window by a power of two. Both errors show on `result` in the cycle right after the offending operands are sampled. No state survives from one operation to the next, so the next operation carries no trace of a fault. Random operands, together with the end cases for length zero, offset zero and overflow past bit 31, expose a wrong stage within a few operations.

// File: rtl/bfp_pkg.sv
package bfp_pkg;

   // Output form of the insertion unit
   typedef enum bit {
      BFP_COMB = 1'b0,
      BFP_REG  = 1'b1
   } bfp_stage_e;

   // True when n is a non-zero power of two
   function automatic bit bfp_is_pow2(input int n);
      return (n > 0) && ((n & (n - 1)) == 0);
   endfunction

endpackage

// File: rtl/bfp_mask_gen.sv
// Shift-left-ones of an all-zero word by len: yields len ones at the bottom.
module bfp_mask_gen #(
   parameter int W     = 32,
   parameter int LEN_W = 4
) (
   input  logic [LEN_W-1:0] len,
   output logic [W-1:0]     mask
);

   logic [LEN_W:0][W-1:0] stg;

   assign stg[0] = '0;

   for (genvar k = 0; k < LEN_W; k++) begin : g_stage
      localparam int S = 1 << k;
      assign stg[k+1] = len[k] ? ((stg[k] << S) | {{(W-S){1'b0}}, {S{1'b1}}})
                               : stg[k];
   end

   assign mask = stg[LEN_W];

   always_comb begin
      if (!$isunknown(len)) begin
         // R1: number of ones matches the requested length
         p_mask_count_r1: assert ($countones(mask) == int'(len));
         // R1: ones are contiguous from bit 0
         p_mask_low_r1: assert ((mask & (mask + W'(1))) == '0);
      end
   end

endmodule

// File: rtl/bfp_pair_shifter.sv
// One logarithmic left shifter whose select lines steer the mask lane and
// the field lane together.
module bfp_pair_shifter #(
   parameter int W     = 32,
   parameter int OFF_W = 5
) (
   input  logic [OFF_W-1:0] off,
   input  logic [W-1:0]     mask_in,
   input  logic [W-1:0]     fld_in,
   output logic [W-1:0]     mask_out,
   output logic [W-1:0]     fld_out
);

   logic [OFF_W:0][2*W-1:0] lane;

   assign lane[0] = {mask_in, fld_in};

   for (genvar k = 0; k < OFF_W; k++) begin : g_stage
      localparam int S = 1 << k;
      logic [W-1:0] hi_sh, lo_sh;
      assign hi_sh = lane[k][2*W-1:W] << S;
      assign lo_sh = lane[k][W-1:0]   << S;
      assign lane[k+1] = off[k] ? {hi_sh, lo_sh} : lane[k];
   end

   assign mask_out = lane[OFF_W][2*W-1:W];
   assign fld_out  = lane[OFF_W][W-1:0];

   always_comb begin
      if (!$isunknown({off, mask_in})) begin
         // R4: shifting can only drop bits past the top, never create them
         p_no_gain_r4: assert ($countones(mask_out) <= $countones(mask_in));
      end
   end

endmodule

// File: rtl/bfp_merge.sv
// Clears the shifted window in the destination and ORs in the shifted field.
module bfp_merge #(
   parameter int W = 32
) (
   input  logic [W-1:0] dst,
   input  logic [W-1:0] win,
   input  logic [W-1:0] fld,
   output logic [W-1:0] merged
);

   assign merged = (dst & ~win) | fld;

   always_comb begin
      if (!$isunknown({win, fld})) begin
         // R3: the shifted field never reaches outside the shifted window
         p_field_in_window_r3: assert ((fld & ~win) == '0);
      end
   end

endmodule

// File: rtl/bfield_insert.sv
module bfield_insert
   import bfp_pkg::*;
#(
   parameter int         DATA_W = 32,
   parameter int         LEN_W  = 4,
   parameter bfp_stage_e STAGE  = BFP_REG
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [DATA_W-1:0]           src_dst,
   input  logic [DATA_W-1:0]           src_fld,
   input  logic [LEN_W-1:0]            len,
   input  logic [$clog2(DATA_W)-1:0]   off,
   output logic [DATA_W-1:0]           result
);

   localparam int OFF_W = $clog2(DATA_W);

   if (!bfp_is_pow2(DATA_W)) begin : g_bad_width
      $error("DATA_W must be a power of two");
   end
   if ((1 << LEN_W) > DATA_W) begin : g_bad_len
      $error("field length range must not exceed DATA_W");
   end

   logic [DATA_W-1:0] mask, fld_trim, win_sh, fld_sh, merged;

   bfp_mask_gen #(.W(DATA_W), .LEN_W(LEN_W)) u_mask (
      .len  (len),
      .mask (mask)
   );

   assign fld_trim = src_fld & mask;

   bfp_pair_shifter #(.W(DATA_W), .OFF_W(OFF_W)) u_shift (
      .off      (off),
      .mask_in  (mask),
      .fld_in   (fld_trim),
      .mask_out (win_sh),
      .fld_out  (fld_sh)
   );

   bfp_merge #(.W(DATA_W)) u_merge (
      .dst    (src_dst),
      .win    (win_sh),
      .fld    (fld_sh),
      .merged (merged)
   );

   if (STAGE == BFP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) result <= '0;
         else        result <= merged;
      end

      // R5: zero length passes the destination through one cycle later
      p_len0_passthru_r5: assert property (@(posedge clk) disable iff (!rst_n)
         (len == '0) |=> (result == $past(src_dst)));

      always_comb begin
         if (rst_n === 1'b0) begin
            // R7: reset holds the output at zero
            p_reset_clear_r7: assert (result == '0);
         end
      end
   end else begin : g_comb
      assign result = merged;
   end

endmodule

// File: tb/sim_bfield_insert.sv
module sim_bfield_insert;

   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] src_dst = '0;
   logic [31:0] src_fld = '0;
   logic [3:0]  len = '0;
   logic [4:0]  off = '0;
   logic [31:0] result;

   int checks = 0;
   int fails  = 0;
   bit done   = 0;

   logic [31:0] exp_q[$];
   string       tag_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   bfield_insert u0 (
      .clk     (clk),
      .rst_n   (rst_n),
      .src_dst (src_dst),
      .src_fld (src_fld),
      .len     (len),
      .off     (off),
      .result  (result)
   );

   function automatic logic [31:0] model(input logic [31:0] d, input logic [31:0] f,
                                         input int l, input int o);
      logic [31:0] r = d;
      for (int j = 0; j < l; j++)
         if (o + j < 32) r[o + j] = f[j];
      return r;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // Driver: apply operands after a falling edge, queue the expected value
   task automatic drive(input string tag, input logic [31:0] d, input logic [31:0] f,
                        input int l, input int o);
      @(negedge clk);
      src_dst = d; src_fld = f; len = 4'(l); off = 5'(o);
      exp_q.push_back(model(d, f, l, o));
      tag_q.push_back(tag);
   endtask

   // Monitor: result is valid just after the edge that sampled the operands
   always @(posedge clk) begin
      #1;
      if (rst_n && exp_q.size() > 0) begin
         logic [31:0] e;
         string t;
         e = exp_q.pop_front();
         t = tag_q.pop_front();
         check(t, result, e);
      end
   end

   initial begin
      #(CLK_PERIOD * 50000);
      if (!done) begin
         fails++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R7 reset clear", result, 32'h0);
      src_dst = 32'hFFFF_FFFF;
      #1;
      check("R7 reset holds", result, 32'h0);
      @(negedge clk);
      rst_n = 1'b1;
      src_dst = '0;

      // R1: mask shape, rs1 zero and field all ones
      drive("R1 len15 off4", 32'h0, 32'hFFFF_FFFF, 15, 4);
      drive("R1 len1 off31", 32'h0, 32'hFFFF_FFFF, 1, 31);
      drive("R1 len7 off9", 32'h0, 32'hFFFF_FFFF, 7, 9);
      // R5: zero length leaves destination intact
      drive("R5 len0", 32'hA5C3_0F96, 32'hFFFF_FFFF, 0, 12);
      drive("R5 len0 off0", 32'h1234_5678, 32'hDEAD_BEEF, 0, 0);
      // R8: offset zero
      drive("R8 off0", 32'hFFFF_FFFF, 32'h0000_0000, 12, 0);
      drive("R8 off0 b", 32'h0000_0000, 32'h0000_5A5A, 15, 0);
      // R4: field runs past bit 31
      drive("R4 overflow", 32'h0000_00FF, 32'hFFFF_FFFF, 15, 28);
      drive("R4 overflow b", 32'h1357_9BDF, 32'h0000_2AAA, 10, 30);
      // R6: upper bits of the field source ignored
      drive("R6 upper noise", 32'h0, 32'hFFFF_FFF0, 4, 8);
      drive("R6 upper noise b", 32'hFFFF_FFFF, 32'hAAAA_8000, 15, 16);
      // R2, R3: random operands
      for (int n = 0; n < 300; n++)
         drive("R2 R3 random", $urandom, $urandom, $urandom_range(0, 15), $urandom_range(0, 31));

      // R7: back-to-back operations each land one cycle later
      drive("R7 pipeline a", 32'h0, 32'h0000_000F, 4, 0);
      drive("R7 pipeline b", 32'h0, 32'h0000_000F, 4, 4);
      drive("R7 pipeline c", 32'h0, 32'h0000_000F, 4, 8);

      @(negedge clk);
      @(negedge clk);
      check("R7 queue drained", 32'(exp_q.size()), 32'h0);
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

endmodule